// File: doc/BRIEF.md
# Timed Register Write Unlock Gate

This block guards a small group of critical configuration registers (clock-source select, clock prescale and watchdog control) against stray writes. It sits beside the core's I/O write bus. A write of a fixed key byte to a dedicated unlock address arms a short window. While the window is armed, a write to one of the guarded addresses is qualified through a per-register allow line. The guarded registers themselves sit outside this block and use that line as their write enable.

The window length is counted in retired instructions, not in clocks. The gate takes the core's instruction-retire strobe for this. The first qualified write consumes the window, so only one guarded update happens per unlock. For as long as the window is armed, the gate raises an interrupt-suppress line so that no handler can run between the key and the guarded write. When the window closes, interrupts that were held back are taken again in their normal priority order by the interrupt logic.

Software can poll the state of the window through the unlock register's read value. Bit 0 shows whether the window is armed, and the upper seven bits always read as zero.

Top module: `cfg_unlock_gate`

## Requirements
- R1: After reset the window is closed: `irq_mask` is 0, `unlock_rdata` is 0x00 and `wr_allow` is all zero.
- R2: A write of the key byte 0xD8 to the unlock address 0x3C arms the window from the following clock cycle.
- R3: A write of any value other than 0xD8 to the unlock address leaves the window closed, or closes it from the next cycle if it is armed.
- R4: An armed window closes in the cycle after its fourth retire strobe. Cycles without a retire strobe do not shorten it, and a retire strobe in the same cycle as the key write is not counted.
- R5: While the window is closed, a write to any guarded address leaves every `wr_allow` bit at zero.
- R6: While the window is armed, a write to a guarded address raises exactly that register's `wr_allow` bit in the same cycle: bit 0 for address 0x31 (watchdog control), bit 1 for 0x36 (prescale) and bit 2 for 0x37 (clock select). A write to any other address raises no bit and does not close the window.
- R7: A qualified guarded write consumes the window, which is closed from the next cycle. This also holds when the write falls in the same cycle as the fourth retire strobe.
- R8: `irq_mask` is 1 in exactly the cycles in which the window is armed.
- R9: `unlock_rdata` bit 0 equals the window state, and bits 7:1 are always zero.
- R10: A key write while the window is armed restarts the full count of four retire strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_en | input | 1 | I/O write strobe for this cycle |
| io_addr | input | 6 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| insn_retire | input | 1 | One instruction retires in this cycle |
| wr_allow | output | 3 | Per guarded register write qualifier (bit 0: 0x31, bit 1: 0x36, bit 2: 0x37) |
| irq_mask | output | 1 | Interrupt suppress while the window is armed |
| unlock_rdata | output | 8 | Read value of the unlock register |

## Verification
Two events can land in the same cycle. One is the fourth retire strobe, which would expire the window. The other is a guarded write, which would consume it. The bench drives a guarded write on exactly that cycle and expects the allow bit to be high there, with the window closed one cycle later from both causes at once. A key rewrite together with a retire strobe is provoked in the same way: the reload must win, and the count then starts again from four. A behavioural counter in the bench predicts every output on every cycle.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

   localparam int unsigned DEF_ADDR_W = 6;
   localparam int unsigned DEF_WINDOW = 4;
   localparam logic [7:0]  DEF_KEY    = 8'hD8;

   // next-state action for the window counter
   typedef enum logic [1:0] {
      WIN_HOLD = 2'd0,
      WIN_LOAD = 2'd1,
      WIN_STEP = 2'd2,
      WIN_SHUT = 2'd3
   } win_op_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cfg_unlock_keydet.sv
module cfg_unlock_keydet #(
   parameter int unsigned       ADDR_W      = 6,
   parameter int unsigned       DATA_W      = 8,
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 6'h3C,
   parameter logic [DATA_W-1:0] KEY         = 8'hD8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              key_hit,
   output logic              key_miss
);

   logic at_unlock;

   always_comb begin
      at_unlock = wr_en && (addr == UNLOCK_ADDR);
      key_hit   = at_unlock && (wdata == KEY);
      key_miss  = at_unlock && (wdata != KEY);
   end

endmodule

// File: rtl/cfg_unlock_match.sv
module cfg_unlock_match #(
   parameter int unsigned                   ADDR_W     = 6,
   parameter int unsigned                   NPROT      = 3,
   parameter logic [NPROT*ADDR_W-1:0]       PROT_ADDRS = {6'h37, 6'h36, 6'h31}
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NPROT-1:0]  hit
);

   for (genvar gi = 0; gi < NPROT; gi++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = PROT_ADDRS[gi*ADDR_W +: ADDR_W];
      assign hit[gi] = wr_en && (addr == SLOT_ADDR);
   end

endmodule

// File: rtl/cfg_unlock_window.sv
module cfg_unlock_window
   import cfg_unlock_pkg::*;
#(
   parameter int unsigned WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic shut,
   input  logic retire,
   output logic open
);

   localparam int unsigned CNT_W = cnt_bits(WINDOW);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] left_d;
   win_op_e          op;

   assign open = (left_q != '0);

   // a reload outranks a close, which outranks a step
   always_comb begin
      if (load)                op = WIN_LOAD;
      else if (shut)           op = WIN_SHUT;
      else if (open && retire) op = WIN_STEP;
      else                     op = WIN_HOLD;
   end

   always_comb begin
      unique case (op)
         WIN_LOAD: left_d = CNT_FULL;
         WIN_SHUT: left_d = '0;
         WIN_STEP: left_d = left_q - CNT_W'(1);
         default:  left_d = left_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left_q <= '0;
      else        left_q <= left_d;
   end

endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate
   import cfg_unlock_pkg::*;
#(
   parameter int unsigned             ADDR_W           = DEF_ADDR_W,
   parameter int unsigned             NPROT            = 3,
   parameter int unsigned             WINDOW           = DEF_WINDOW,
   parameter logic [ADDR_W-1:0]       UNLOCK_ADDR      = 6'h3C,
   parameter logic [7:0]              KEY              = DEF_KEY,
   parameter logic [NPROT*ADDR_W-1:0] PROT_ADDRS       = {6'h37, 6'h36, 6'h31},
   parameter bit                      CONSUME_ON_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              insn_retire,
   output logic [NPROT-1:0]  wr_allow,
   output logic              irq_mask,
   output logic [7:0]        unlock_rdata
);

   localparam int unsigned DATA_W = 8;

   // elaboration-time parameter checks
   if (WINDOW < 1) begin : g_bad_window
      $error("cfg_unlock_gate: WINDOW must be at least 1");
   end
   if (NPROT < 1) begin : g_bad_nprot
      $error("cfg_unlock_gate: NPROT must be at least 1");
   end
   for (genvar gc = 0; gc < NPROT; gc++) begin : g_addr_chk
      if (PROT_ADDRS[gc*ADDR_W +: ADDR_W] == UNLOCK_ADDR) begin : g_clash
         $error("cfg_unlock_gate: guarded address equals unlock address");
      end
   end

   logic             key_hit;
   logic             key_miss;
   logic [NPROT-1:0] slot_hit;
   logic             win_open;
   logic             consume;

   cfg_unlock_keydet #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .UNLOCK_ADDR (UNLOCK_ADDR),
      .KEY         (KEY)
   ) keydet_i (
      .wr_en    (io_wr_en),
      .addr     (io_addr),
      .wdata    (io_wdata),
      .key_hit  (key_hit),
      .key_miss (key_miss)
   );

   cfg_unlock_match #(
      .ADDR_W     (ADDR_W),
      .NPROT      (NPROT),
      .PROT_ADDRS (PROT_ADDRS)
   ) match_i (
      .wr_en (io_wr_en),
      .addr  (io_addr),
      .hit   (slot_hit)
   );

   assign wr_allow = slot_hit & {NPROT{win_open}};

   if (CONSUME_ON_WRITE) begin : g_consume
      assign consume = |wr_allow;
   end else begin : g_no_consume
      assign consume = 1'b0;
   end

   cfg_unlock_window #(
      .WINDOW (WINDOW)
   ) window_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (key_hit),
      .shut   (key_miss | consume),
      .retire (insn_retire),
      .open   (win_open)
   );

   assign irq_mask     = win_open;
   assign unlock_rdata = {7'b0, win_open};

endmodule

// File: rtl/cfg_unlock_gate_chk.sv
module cfg_unlock_gate_chk #(
   parameter int unsigned       ADDR_W      = 6,
   parameter int unsigned       NPROT       = 3,
   parameter int unsigned       WINDOW      = 4,
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 6'h3C,
   parameter logic [7:0]        KEY         = 8'hD8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr_en,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              insn_retire,
   input logic [NPROT-1:0]  wr_allow,
   input logic              irq_mask
);

   logic key_wr;
   logic other_wr;
   int   seen;

   assign key_wr   = io_wr_en && (io_addr == UNLOCK_ADDR) && (io_wdata == KEY);
   assign other_wr = io_wr_en && (io_addr == UNLOCK_ADDR) && (io_wdata != KEY);

   // retire strobes seen since the window was armed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           seen <= 0;
      else if (key_wr)      seen <= 0;
      else if (!irq_mask)   seen <= 0;
      else if (insn_retire) seen <= seen + 1;
   end

   a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> irq_mask);

   a_r3_other_value_shuts: assert property (@(posedge clk) disable iff (!rst_n)
      other_wr |=> !irq_mask);

   a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> (seen < int'(WINDOW)));

   a_r5_allow_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_allow) |-> irq_mask);

   a_r6_allow_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_allow));

   a_r7_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_allow) |=> !irq_mask);

   a_r8_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_mask && !key_wr) |=> !irq_mask);

endmodule

bind cfg_unlock_gate cfg_unlock_gate_chk #(
   .ADDR_W      (ADDR_W),
   .NPROT       (NPROT),
   .WINDOW      (WINDOW),
   .UNLOCK_ADDR (UNLOCK_ADDR),
   .KEY         (KEY)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_wr_en    (io_wr_en),
   .io_addr     (io_addr),
   .io_wdata    (io_wdata),
   .insn_retire (insn_retire),
   .wr_allow    (wr_allow),
   .irq_mask    (irq_mask)
);

// File: tb/cfg_unlock_gate_tb_top.sv
`timescale 1ns/1ps
module cfg_unlock_gate_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       io_wr_en = 1'b0;
   logic [5:0] io_addr = '0;
   logic [7:0] io_wdata = '0;
   logic       insn_retire = 1'b0;
   logic [2:0] wr_allow;
   logic       irq_mask;
   logic [7:0] unlock_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   int left   = 0;    // model: retire strobes remaining in the window
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   cfg_unlock_gate dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .io_wr_en     (io_wr_en),
      .io_addr      (io_addr),
      .io_wdata     (io_wdata),
      .insn_retire  (insn_retire),
      .wr_allow     (wr_allow),
      .irq_mask     (irq_mask),
      .unlock_rdata (unlock_rdata)
   );

   function automatic logic [2:0] exp_allow();
      logic [2:0] e = '0;
      if (io_wr_en && left > 0) begin
         e[0] = (io_addr == 6'h31);
         e[1] = (io_addr == 6'h36);
         e[2] = (io_addr == 6'h37);
      end
      return e;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "wr_allow", int'(wr_allow), int'(exp_allow()));
      chk({tag, "/R8"}, "irq_mask", int'(irq_mask), (left > 0) ? 1 : 0);
      chk("R9", "unlock_rdata", int'(unlock_rdata), (left > 0) ? 1 : 0);
   endtask

   // one cycle: drive away from the edge, compare, then advance the model
   task automatic step(input string tag, input logic wr, input logic [5:0] a,
                       input logic [7:0] d, input logic ret);
      @(negedge clk);
      io_wr_en = wr; io_addr = a; io_wdata = d; insn_retire = ret;
      #1;
      compare(tag);
      @(posedge clk);
      if (wr && a == 6'h3C)  left = (d == 8'hD8) ? 4 : 0;
      else if (|exp_allow()) left = 0;
      else if (left > 0 && ret) left = left - 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; compare("R1");
      @(negedge clk); rst_n = 1'b1;
      #1; compare("R1");

      // R5: guarded writes while closed
      step("R5", 1, 6'h31, 8'h55, 1);
      step("R5", 1, 6'h37, 8'h01, 0);
      // R3: wrong value keeps it closed
      step("R3", 1, 6'h3C, 8'hD9, 0);
      step("R3", 0, 6'h00, 8'h00, 0);

      // R2 with a retire in the same cycle (R4: not counted)
      step("R2", 1, 6'h3C, 8'hD8, 1);
      step("R4", 0, 6'h00, 8'h00, 0);
      step("R4", 0, 6'h00, 8'h00, 0);
      step("R6", 1, 6'h20, 8'h12, 1);     // other address, no consume
      step("R4", 0, 6'h00, 8'h00, 1);
      step("R4", 0, 6'h00, 8'h00, 1);
      step("R6", 1, 6'h36, 8'h03, 0);     // qualified write
      step("R7", 1, 6'h36, 8'h04, 0);     // consumed: now refused

      // R4: four retires expire the window
      step("R2", 1, 6'h3C, 8'hD8, 0);
      for (int i = 0; i < 4; i++) step("R4", 0, 6'h00, 8'h00, 1);
      step("R5", 1, 6'h31, 8'hAA, 0);

      // R3: wrong value while armed closes it
      step("R2", 1, 6'h3C, 8'hD8, 0);
      step("R3", 1, 6'h3C, 8'h01, 1);
      step("R3", 1, 6'h37, 8'h02, 0);

      // R10: rewrite restarts the count (with a retire on the rewrite)
      step("R2", 1, 6'h3C, 8'hD8, 0);
      step("R10", 0, 6'h00, 8'h00, 1);
      step("R10", 0, 6'h00, 8'h00, 1);
      step("R10", 1, 6'h3C, 8'hD8, 1);
      for (int i = 0; i < 4; i++) step("R10", 0, 6'h00, 8'h00, 1);
      step("R10", 0, 6'h00, 8'h00, 0);

      // R7: guarded write on the fourth retire
      step("R2", 1, 6'h3C, 8'hD8, 0);
      for (int i = 0; i < 3; i++) step("R4", 0, 6'h00, 8'h00, 1);
      step("R7", 1, 6'h37, 8'h07, 1);
      step("R7", 1, 6'h31, 8'h08, 0);

      // R6: each slot in turn
      step("R2", 1, 6'h3C, 8'hD8, 0);
      step("R6", 1, 6'h31, 8'h11, 0);
      step("R2", 1, 6'h3C, 8'hD8, 0);
      step("R6", 1, 6'h37, 8'h22, 0);
      step("R8", 0, 6'h00, 8'h00, 0);

      finish_run();
   end

endmodule